// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It implements a small integer subset: five register-to-register operations (add, sub, and, or, set-on-less-than), a word load, a word store, a branch taken when two registers are equal, and an unconditional jump. The program counter, the register file, the ALU, the sign extender and the next-address logic live in a datapath module. A separate control module decodes the opcode and function fields into a packed bundle of strobes that steers the datapath.

Instruction memory and data memory sit outside the core. The core drives an instruction address and expects the matching instruction word back in the same cycle. Data memory is read combinationally and written on the rising clock edge when the core raises its store strobe. A system integrator places the core next to two word-addressed arrays, loads the program, and releases reset. Execution then starts at address zero.

Top module: `scc_core`

## Requirements
- R1: While `rstN` is low, `instrAddr` is 0 and `dataWrEn` is 0, whatever instruction word is presented. The first instruction after reset is the one fetched from address 0.
- R2: When the opcode (bits 31-26) is 0, the core selects an operation by the function code (bits 5-0): add=32, sub=34, and=36, or=37, slt=42. It applies that operation to the registers named by bits 25-21 (first source) and bits 20-16 (second source). The result goes to the register named by bits 15-11.
- R3: slt writes 1 when the first source is less than the second as signed 32-bit numbers, and writes 0 otherwise, including when the two are equal.
- R4: Opcode 35 loads the data word at address (first source + sign-extended bits 15-0) into the register named by bits 20-16.
- R5: Opcode 43 writes the register named by bits 20-16 to address (first source + sign-extended bits 15-0). A store changes no register, whatever bits 15-11 contain.
- R6: Opcode 4 compares the two source registers. When they are equal, the next address is PC+4 plus the sign-extended bits 15-0 shifted left by 2, and this can be a backward target. When they differ, the next address is PC+4.
- R7: Opcode 2 jumps to the address formed from PC+4 bits 31-28, then instruction bits 25-0, then two zero bits.
- R8: Register 0 always reads as zero. Loads and register operations that name it as destination have no visible effect.
- R9: Every instruction other than a taken branch or a jump advances the PC by 4, one instruction per clock cycle.
- R10: An unknown opcode, or opcode 0 with an unknown function code, writes no register and no memory, and the core advances to PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| instrAddr | output | 32 | Byte address of the current instruction (PC) |
| instrData | input | 32 | Instruction word at `instrAddr`, same cycle |
| dataAddr | output | 32 | Byte address for a load or store |
| dataWrEn | output | 1 | Store strobe; memory writes on the next rising edge |
| dataWrData | output | 32 | Word to store |
| dataRdData | input | 32 | Word read from `dataAddr`, same cycle |

## Verification
The core keeps no state apart from the PC and the register file, so any internal fault shows up at the memory ports. A wrong PC shows on `instrAddr` at the very next edge. A bad decode of control flow sends the fetch address to a wrong place within one cycle. A wrong register value or a stray register write stays hidden until a later store puts that register on `dataWrData`. For that reason the tests route every computed or guarded register out through a store and compare the data array afterwards, and they also sample `instrAddr` at the cycles where a branch or jump has just retired.

// File: rtl/scc_pkg.sv
package scc_pkg;
  localparam int XLEN   = 32;
  localparam int REG_AW = 5;
  localparam int NREG   = 1 << REG_AW;

  localparam logic [5:0] OPC_REG  = 6'd0;
  localparam logic [5:0] OPC_LOAD = 6'd35;
  localparam logic [5:0] OPC_STOR = 6'd43;
  localparam logic [5:0] OPC_BEQ  = 6'd4;
  localparam logic [5:0] OPC_JMP  = 6'd2;

  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluOp_e;

  typedef struct packed {
    logic   destIsRd;
    logic   srcBIsImm;
    logic   wbFromMem;
    logic   regWrite;
    logic   memWrite;
    logic   isBranch;
    logic   isJump;
    aluOp_e aluOp;
  } ctrl_t;
endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    case (opcode)
      OPC_REG: begin
        ctrl.destIsRd = 1'b1;
        ctrl.regWrite = 1'b1;
        case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          default: ctrl.regWrite = 1'b0;  // unknown function: R10
        endcase
      end
      OPC_LOAD: begin
        ctrl.srcBIsImm = 1'b1;
        ctrl.wbFromMem = 1'b1;
        ctrl.regWrite  = 1'b1;
      end
      OPC_STOR: begin
        ctrl.srcBIsImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.isBranch = 1'b1;
        ctrl.aluOp    = ALU_SUB;
      end
      OPC_JMP: ctrl.isJump = 1'b1;
      default: ;  // unknown opcode: R10
    endcase
  end

  always_comb begin
    p_store_no_wb_r5: assert (!(ctrl.memWrite && ctrl.regWrite));
  end
endmodule

// File: rtl/scc_alu.sv
module scc_alu
  import scc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  aluOp_e         op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   result,
  output logic           zero
);
  always_comb begin
    case (op)
      ALU_ADD: result = a + b;
      ALU_SUB: result = a - b;
      ALU_AND: result = a & b;
      ALU_OR:  result = a | b;
      ALU_SLT: result = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: result = '0;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/scc_regfile.sv
module scc_regfile
  import scc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int AW = REG_AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] rdAddrA,
  input  logic [AW-1:0] rdAddrB,
  output logic [W-1:0]  rdDataA,
  output logic [W-1:0]  rdDataB,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  localparam int N = 1 << AW;

  logic [W-1:0] regs [N];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr != '0)) |=> (regs[$past(wrAddr)] == $past(wrData)));
endmodule

// File: rtl/scc_datapath.sv
module scc_datapath
  import scc_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  input  logic [25:0]     instrLow,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] dataAddr,
  output logic            dataWrEn,
  output logic [XLEN-1:0] dataWrData,
  input  logic [XLEN-1:0] dataRdData
);
  logic [REG_AW-1:0] rsIdx, rtIdx, rdIdx, wrIdx;
  logic [15:0]       imm16;
  logic [XLEN-1:0]   rsVal, rtVal, immExt, aluB, aluRes, wbData;
  logic [XLEN-1:0]   pcPlus4, branchTarget, jumpTarget, pcNext;
  logic              aluZero, takeBranch;

  assign rsIdx = instrLow[25:21];
  assign rtIdx = instrLow[20:16];
  assign rdIdx = instrLow[15:11];
  assign imm16 = instrLow[15:0];

  assign immExt = {{(XLEN-16){imm16[15]}}, imm16};
  assign wrIdx  = ctrl.destIsRd ? rdIdx : rtIdx;
  assign aluB   = ctrl.srcBIsImm ? immExt : rtVal;
  assign wbData = ctrl.wbFromMem ? dataRdData : aluRes;

  scc_regfile #(.W(XLEN), .AW(REG_AW)) rf_i (
    .clk     (clk),
    .rstN    (rstN),
    .rdAddrA (rsIdx),
    .rdAddrB (rtIdx),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrIdx),
    .wrData  (wbData)
  );

  scc_alu #(.W(XLEN)) alu_i (
    .op     (ctrl.aluOp),
    .a      (rsVal),
    .b      (aluB),
    .result (aluRes),
    .zero   (aluZero)
  );

  assign pcPlus4      = pc + XLEN'(4);
  assign branchTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jumpTarget   = {pcPlus4[XLEN-1:XLEN-4], instrLow, 2'b00};
  assign takeBranch   = ctrl.isBranch & aluZero;

  always_comb begin
    if (ctrl.isJump)      pcNext = jumpTarget;
    else if (takeBranch)  pcNext = branchTarget;
    else                  pcNext = pcPlus4;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pc <= RESET_PC;
    else       pc <= pcNext;
  end

  assign dataAddr   = aluRes;
  assign dataWrData = rtVal;
  assign dataWrEn   = ctrl.memWrite & rstN;

  p_seq_pc_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.isJump && !ctrl.isBranch) |=> (pc == $past(pc) + XLEN'(4)));

  p_beq_taken_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.isBranch && (rsVal == rtVal)) |=>
      (pc == $past(pc) + XLEN'(4) + {$past(immExt[XLEN-3:0]), 2'b00}));

  p_beq_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.isBranch && (rsVal != rtVal)) |=> (pc == $past(pc) + XLEN'(4)));

  p_jump_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.isJump |=> (pc == {$past(pcPlus4[XLEN-1:XLEN-4]), $past(instrLow), 2'b00}));

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rsIdx == '0) |-> (rsVal == '0));
endmodule

// File: rtl/scc_core.sv
module scc_core
  import scc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  output logic [31:0] instrAddr,
  input  logic [31:0] instrData,
  output logic [31:0] dataAddr,
  output logic        dataWrEn,
  output logic [31:0] dataWrData,
  input  logic [31:0] dataRdData
);
  ctrl_t ctrlBus;

  scc_ctrl ctrl_i (
    .opcode (instrData[31:26]),
    .funct  (instrData[5:0]),
    .ctrl   (ctrlBus)
  );

  scc_datapath #(.RESET_PC(RESET_PC)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrlBus),
    .instrLow   (instrData[25:0]),
    .pc         (instrAddr),
    .dataAddr   (dataAddr),
    .dataWrEn   (dataWrEn),
    .dataWrData (dataWrData),
    .dataRdData (dataRdData)
  );
endmodule

// File: tb/scc_core_tb_top.sv
module scc_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] instrAddr, instrData, dataAddr, dataWrData, dataRdData;
  logic        dataWrEn;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  assign instrData  = imem[instrAddr[7:2]];
  assign dataRdData = dmem[dataAddr[7:2]];

  always @(posedge clk) begin
    if (dataWrEn) dmem[dataAddr[7:2]] <= dataWrData;
  end

  scc_core dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .instrAddr  (instrAddr),
    .instrData  (instrData),
    .dataAddr   (dataAddr),
    .dataWrEn   (dataWrEn),
    .dataWrData (dataWrData),
    .dataRdData (dataRdData)
  );

  function automatic logic [31:0] encR(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encJ(logic [25:0] tgt);
    return {6'd2, tgt};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prepare();
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic release_and_run(int n);
    @(negedge clk);
    rstN = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    prepare();
    dmem[0] = 32'h11;
    imem[0] = encI(6'd43, 5'd0, 5'd0, 16'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pc in reset", instrAddr, 32'h0);
    check("R1 store strobe in reset", {31'b0, dataWrEn}, 32'h0);
    check("R1 memory untouched in reset", dmem[0], 32'h11);
    release_and_run(1);
    check("R1 first instruction from address 0", dmem[0], 32'h0);
  endtask

  task automatic t_alu();
    prepare();
    dmem[0] = 32'd100;
    dmem[1] = 32'hFFFF_FFFD;
    imem[0] = encI(6'd35, 5'd0, 5'd1, 16'd0);
    imem[1] = encI(6'd35, 5'd0, 5'd2, 16'd4);
    imem[2] = encR(6'd32, 5'd1, 5'd2, 5'd3);
    imem[3] = encR(6'd34, 5'd1, 5'd2, 5'd4);
    imem[4] = encR(6'd36, 5'd1, 5'd2, 5'd5);
    imem[5] = encR(6'd37, 5'd1, 5'd2, 5'd6);
    imem[6] = encR(6'd42, 5'd1, 5'd2, 5'd7);
    imem[7] = encR(6'd42, 5'd2, 5'd1, 5'd8);
    imem[8] = encR(6'd42, 5'd1, 5'd1, 5'd9);
    for (int k = 0; k < 7; k++)
      imem[9+k] = encI(6'd43, 5'd0, 5'(3+k), 16'(16 + 4*k));
    imem[16] = encJ(26'd16);
    release_and_run(2);
    check("R9 pc after two loads", instrAddr, 32'd8);
    run(20);
    check("R2 add", dmem[4], 32'd97);
    check("R2 sub", dmem[5], 32'd103);
    check("R2 and", dmem[6], 32'h64);
    check("R2 or", dmem[7], 32'hFFFF_FFFD);
    check("R3 slt positive vs negative", dmem[8], 32'd0);
    check("R3 slt negative vs positive", dmem[9], 32'd1);
    check("R3 slt equal", dmem[10], 32'd0);
    check("R7 halt loop holds pc", instrAddr, 32'd64);
  endtask

  task automatic t_mem();
    prepare();
    dmem[2] = 32'd40;
    dmem[9] = 32'h1234_5678;
    imem[0] = encI(6'd35, 5'd0, 5'd1, 16'd8);
    imem[1] = encI(6'd35, 5'd1, 5'd2, 16'hFFFC);
    imem[2] = encI(6'd43, 5'd1, 5'd2, 16'hFFF8);
    imem[3] = encI(6'd43, 5'd0, 5'd31, 16'd40);
    imem[4] = encJ(26'd4);
    release_and_run(8);
    check("R4 R5 load then store with negative offsets", dmem[8], 32'h1234_5678);
    check("R4 load source unchanged", dmem[9], 32'h1234_5678);
    check("R5 store wrote no register", dmem[10], 32'h0);
  endtask

  task automatic t_branch();
    prepare();
    dmem[0] = 32'd5;
    dmem[1] = 32'd5;
    dmem[2] = 32'd6;
    imem[0] = encI(6'd35, 5'd0, 5'd1, 16'd0);
    imem[1] = encI(6'd35, 5'd0, 5'd2, 16'd4);
    imem[2] = encI(6'd35, 5'd0, 5'd3, 16'd8);
    imem[3] = encI(6'd4, 5'd1, 5'd3, 16'd2);
    imem[4] = encI(6'd43, 5'd0, 5'd1, 16'd48);
    imem[5] = encI(6'd4, 5'd1, 5'd2, 16'd2);
    imem[6] = encI(6'd43, 5'd0, 5'd1, 16'd52);
    imem[7] = encI(6'd43, 5'd0, 5'd1, 16'd56);
    imem[8] = encI(6'd43, 5'd0, 5'd3, 16'd60);
    imem[9] = encJ(26'd9);
    release_and_run(4);
    check("R6 branch not taken falls through", instrAddr, 32'd16);
    run(2);
    check("R6 branch taken target", instrAddr, 32'd32);
    run(6);
    check("R6 fall-through store executed", dmem[12], 32'd5);
    check("R6 skipped store one", dmem[13], 32'd0);
    check("R6 skipped store two", dmem[14], 32'd0);
    check("R6 target store executed", dmem[15], 32'd6);
  endtask

  task automatic t_jump();
    prepare();
    imem[0] = encJ(26'h200_0004);
    imem[4] = encJ(26'd6);
    imem[6] = encI(6'd4, 5'd0, 5'd0, 16'hFFFF);
    release_and_run(1);
    check("R7 jump with high target bits", instrAddr, 32'h0800_0010);
    run(1);
    check("R7 jump keeps top PC+4 bits", instrAddr, 32'h18);
    run(3);
    check("R6 backward branch to itself", instrAddr, 32'h18);
  endtask

  task automatic t_zero_reg();
    prepare();
    dmem[0] = 32'hDEAD_BEEF;
    imem[0] = encI(6'd35, 5'd0, 5'd0, 16'd0);
    imem[1] = encI(6'd35, 5'd0, 5'd1, 16'd0);
    imem[2] = encR(6'd32, 5'd1, 5'd1, 5'd0);
    imem[3] = encI(6'd43, 5'd0, 5'd0, 16'd64);
    imem[4] = encR(6'd32, 5'd0, 5'd1, 5'd2);
    imem[5] = encI(6'd43, 5'd0, 5'd2, 16'd68);
    imem[6] = encJ(26'd6);
    release_and_run(9);
    check("R8 register zero stays zero", dmem[16], 32'h0);
    check("R8 zero operand in add", dmem[17], 32'hDEAD_BEEF);
  endtask

  task automatic t_illegal();
    prepare();
    dmem[0] = 32'h55;
    imem[0] = encI(6'd35, 5'd0, 5'd9, 16'd0);
    imem[1] = 32'hFFFF_FFFF;
    imem[2] = encR(6'h3F, 5'd9, 5'd9, 5'd9);
    imem[3] = encI(6'd43, 5'd0, 5'd9, 16'd72);
    imem[4] = encI(6'd43, 5'd0, 5'd31, 16'd76);
    imem[5] = encJ(26'd5);
    release_and_run(3);
    check("R10 unknown codes advance pc", instrAddr, 32'd12);
    run(4);
    check("R10 unknown function wrote no register", dmem[18], 32'h55);
    check("R10 unknown opcode wrote no register", dmem[19], 32'h0);
    check("R10 unknown opcode stored nothing", dmem[63], 32'h0);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_jump();
    t_zero_reg();
    t_illegal();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end
endmodule